// File: doc/BRIEF.md
# Hotspot-Selected ROM/RAM Bank Mapper

This block decodes the 13-bit address bus of an 8-bit CPU for a 4 KB cartridge window. The window is selected by address bit 12. The top 2 KB of the window always shows the last ROM bank. The bottom 2 KB shows one of two things: a switchable ROM bank, or a switchable 1 KB RAM bank. In RAM mode, reads and writes of that RAM use separate address halves.

Software picks the lower-window contents by writing to one of two hotspot addresses in the peripheral region below the window. One hotspot selects a ROM bank and the other selects a RAM bank. Every write to that peripheral region, hotspot or not, is passed through unchanged to the console peripheral port.

A read from the RAM write half has a side effect: it corrupts the addressed RAM byte with the floating value on the data bus. A debugger can suppress this side effect with a lock input. Each corrupting read is reported one cycle later on an event output, together with the address that caused it.

Top module: `hsbank_mapper`

## Requirements
- R1: After reset the lower window is in ROM mode with ROM bank 0 selected, and `rwp_event` is low.
- R2: A write with addr[12]=0 and addr[11:0]=0x03F selects ROM mode and ROM bank wr_data modulo ROM_BANKS for the lower window, starting with the next cycle.
- R3: A write with addr[12]=0 and addr[11:0]=0x03E selects RAM mode and RAM bank wr_data modulo RAM_BANKS, held internally as a 9-bit code equal to the bank number plus 256.
- R4: In the same cycle, every write with addr[12]=0 and addr[11:6]=0 (hotspots included) raises `periph_we`, with `periph_addr`=addr[5:0] and `periph_wdata`=wr_data. Other writes leave `periph_we` low.
- R5: A read of window offset 0x800–0xFFF returns the last ROM bank (ROM_BANKS-1), whatever is selected.
- R6: In RAM mode, a read of offset 0x000–0x3FF returns RAM[bank*1024 + addr[9:0]]. A write to offset 0x400–0x7FF stores wr_data at the same index.
- R7: In RAM mode, a read (rd_en high, wr_en low) of offset 0x400–0x7FF returns bus_float. When bank_lock is low, it also stores bus_float at RAM[bank*1024 + addr[9:0]].
- R8: With bank_lock high, such a read leaves RAM unchanged and raises no event.
- R9: In the cycle after each unlocked read of the RAM write half, `rwp_event` is high for exactly one cycle and `rwp_addr` holds the full address of that read.
- R10: Writes to the lower window in ROM mode and writes to offset 0x800–0xFFF change nothing. `rd_data` is 0 when there is no read or the address lies outside the window.
- R11: ROM bank b at 11-bit offset o holds the byte ((o[7:0] XOR (b*0x11)) + o[10:8]) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 13 | CPU address |
| wr_data | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (takes precedence over rd_en) |
| bus_float | input | 8 | Value left floating on the data bus |
| bank_lock | input | 1 | Suppresses corruption on write-half reads |
| rd_data | output | 8 | Read data (combinational) |
| periph_we | output | 1 | Peripheral write pass-through strobe |
| periph_addr | output | 6 | Peripheral register offset |
| periph_wdata | output | 8 | Peripheral write data |
| rwp_event | output | 1 | Accidental-write event, one cycle after the read |
| rwp_addr | output | 13 | Address of the read that raised the event |

## Verification
The assertions check the following on every cycle:
- the hotspot writes land in the selection register;
- peripheral strobes only occur below the window;
- the upper half is always routed to the last ROM bank;
- write-half reads return the bus value;
- each event traces back to an unlocked read at the same address;
- RAM writes take effect.

Only the bench's scenarios can show the following:
- that corrupted bytes read back through the read half later;
- that a locked read leaves the byte intact;
- that ROM-mode writes to the write half leave RAM untouched;
- that bank numbers wrap modulo the bank count over long random sequences.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

  // Address classes seen by the mapper
  typedef enum logic [2:0] {
    RG_FOREIGN = 3'd0,  // below the window, above the peripheral span
    RG_PERIPH  = 3'd1,  // peripheral span holding the hotspots
    RG_LOW_A   = 3'd2,  // window 0x000-0x3FF
    RG_LOW_B   = 3'd3,  // window 0x400-0x7FF
    RG_HIGH    = 3'd4   // window 0x800-0xFFF
  } region_e;

  localparam int          SEL_W      = 9;
  localparam logic [5:0]  HOT_ROM    = 6'h3F;
  localparam logic [5:0]  HOT_RAM    = 6'h3E;
  localparam logic [8:0]  RAM_MARK   = 9'd256;

  // Synthetic ROM image, computed rather than stored
  function automatic logic [7:0] rom_byte(input logic [7:0] bank, input logic [10:0] off);
    logic [7:0] mix;
    mix = off[7:0] ^ (bank * 8'h11);
    return mix + {5'b0, off[10:8]};
  endfunction

endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
  import bankmap_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int PERIPH_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [ADDR_W-3:0] half_off
);
  localparam int WIN_W = ADDR_W - 1;

  logic [WIN_W-1:0] off;

  always_comb begin
    off      = addr[WIN_W-1:0];
    half_off = off[WIN_W-2:0];
    if (addr[ADDR_W-1]) begin
      if (off[WIN_W-1])      region = RG_HIGH;
      else if (off[WIN_W-2]) region = RG_LOW_B;
      else                   region = RG_LOW_A;
    end else if (off[WIN_W-1:PERIPH_W] == '0) begin
      region = RG_PERIPH;
    end else begin
      region = RG_FOREIGN;
    end
  end

endmodule

// File: rtl/bankmap_select.sv
module bankmap_select
  import bankmap_pkg::*;
#(
  parameter int RB_W  = 2,
  parameter int RAB_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_we,
  input  logic [5:0]       hs_off,
  input  logic [7:0]       wdata,
  output logic             ram_mode,
  output logic [RB_W-1:0]  rom_bank,
  output logic [RAB_W-1:0] ram_bank
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en;

  // next state
  always_comb begin
    sel_en = hs_we && ((hs_off == HOT_ROM) || (hs_off == HOT_RAM));
    sel_d  = sel_q;
    if (hs_we && hs_off == HOT_ROM)      sel_d = {1'b0, wdata};
    else if (hs_we && hs_off == HOT_RAM) sel_d = {1'b0, wdata} + RAM_MARK;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign ram_mode = sel_q[SEL_W-1];
  assign rom_bank = sel_q[RB_W-1:0];
  assign ram_bank = sel_q[RAB_W-1:0];

  p_rom_hot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_we && hs_off == HOT_ROM) |=> (!ram_mode && sel_q[7:0] == $past(wdata)));

  p_ram_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_we && hs_off == HOT_RAM) |=> (ram_mode && sel_q[7:0] == $past(wdata)));

endmodule

// File: rtl/bankmap_rom.sv
module bankmap_rom
  import bankmap_pkg::*;
#(
  parameter int RB_W  = 2,
  parameter int OFF_W = 11
) (
  input  logic [RB_W-1:0]  bank,
  input  logic [OFF_W-1:0] off,
  output logic [7:0]       data
);
  logic [7:0] bank8;

  assign bank8 = 8'(bank);
  assign data  = rom_byte(bank8, off);

endmodule

// File: rtl/bankmap_ram.sv
module bankmap_ram #(
  parameter int RAB_W = 1,
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  localparam int IDX_W = RAB_W + OFF_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

  p_ram_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/hsbank_mapper.sv
module hsbank_mapper
  import bankmap_pkg::*;
#(
  parameter int ROM_BANKS = 4,
  parameter int RAM_BANKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [12:0] addr,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  bus_float,
  input  logic        bank_lock,
  output logic [7:0]  rd_data,
  output logic        periph_we,
  output logic [5:0]  periph_addr,
  output logic [7:0]  periph_wdata,
  output logic        rwp_event,
  output logic [12:0] rwp_addr
);
  localparam int ADDR_W    = 13;
  localparam int HALF_W    = ADDR_W - 2;
  localparam int RAM_OFF_W = HALF_W - 1;
  localparam int PERIPH_W  = 6;
  localparam int RB_W      = $clog2(ROM_BANKS);
  localparam int RAB_W     = $clog2(RAM_BANKS);
  localparam logic [RB_W-1:0] LAST_BANK = RB_W'(ROM_BANKS - 1);

  region_e            region;
  logic [HALF_W-1:0]  half_off;
  logic               ram_mode;
  logic [RB_W-1:0]    sel_rom_bank;
  logic [RAB_W-1:0]   sel_ram_bank;
  logic [RB_W-1:0]    rom_bank_mux;
  logic [7:0]         rom_data;
  logic [7:0]         ram_rdata;
  logic [7:0]         ram_wdata;
  logic               ram_we;
  logic               rd_act;
  logic               wp_read;
  logic               rwp_event_d;
  logic               rwp_addr_en;
  logic [ADDR_W-1:0]  rwp_addr_d;
  logic               rwp_event_q;
  logic [ADDR_W-1:0]  rwp_addr_q;

  bankmap_decode #(.ADDR_W(ADDR_W), .PERIPH_W(PERIPH_W)) u_decode (
    .addr     (addr),
    .region   (region),
    .half_off (half_off)
  );

  bankmap_select #(.RB_W(RB_W), .RAB_W(RAB_W)) u_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .hs_we    (periph_we),
    .hs_off   (periph_addr),
    .wdata    (wr_data),
    .ram_mode (ram_mode),
    .rom_bank (sel_rom_bank),
    .ram_bank (sel_ram_bank)
  );

  assign rom_bank_mux = (region == RG_HIGH) ? LAST_BANK : sel_rom_bank;

  bankmap_rom #(.RB_W(RB_W), .OFF_W(HALF_W)) u_rom (
    .bank (rom_bank_mux),
    .off  (half_off),
    .data (rom_data)
  );

  bankmap_ram #(.RAB_W(RAB_W), .OFF_W(RAM_OFF_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .idx   ({sel_ram_bank, half_off[RAM_OFF_W-1:0]}),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  // Access classification
  always_comb begin
    rd_act    = rd_en && !wr_en;
    wp_read   = rd_act && ram_mode && (region == RG_LOW_B);
    ram_we    = (wr_en && ram_mode && (region == RG_LOW_B)) || (wp_read && !bank_lock);
    ram_wdata = wr_en ? wr_data : bus_float;
  end

  // Read data path
  always_comb begin
    rd_data = '0;
    if (rd_act) begin
      unique case (region)
        RG_HIGH:  rd_data = rom_data;
        RG_LOW_A: rd_data = ram_mode ? ram_rdata : rom_data;
        RG_LOW_B: rd_data = ram_mode ? bus_float : rom_data;
        default:  rd_data = '0;
      endcase
    end
  end

  // Peripheral pass-through
  assign periph_we    = wr_en && (region == RG_PERIPH);
  assign periph_addr  = addr[PERIPH_W-1:0];
  assign periph_wdata = wr_data;

  // Accidental-write event: next state
  always_comb begin
    rwp_event_d = wp_read && !bank_lock;
    rwp_addr_en = rwp_event_d;
    rwp_addr_d  = addr;
  end

  // Accidental-write event: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwp_event_q <= 1'b0;
      rwp_addr_q  <= '0;
    end else begin
      rwp_event_q <= rwp_event_d;
      if (rwp_addr_en) rwp_addr_q <= rwp_addr_d;
    end
  end

  assign rwp_event = rwp_event_q;
  assign rwp_addr  = rwp_addr_q;

  p_periph_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    periph_we |-> (!addr[12] && wr_en));

  p_high_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && addr[12] && addr[11]) |-> (rom_bank_mux == LAST_BANK));

  p_wp_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_read |-> (rd_data == bus_float));

  p_lock_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_read && bank_lock) |=> !rwp_event);

  p_event_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rwp_event |-> ($past(rd_en && !wr_en && !bank_lock) && rwp_addr == $past(addr)));

endmodule

// File: tb/hsbank_mapper_bench.sv
module hsbank_mapper_bench;
  localparam int NROM = 4;
  localparam int NRAM = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] addr;
  logic [7:0]  wr_data;
  logic        rd_en;
  logic        wr_en;
  logic [7:0]  bus_float;
  logic        bank_lock;
  logic [7:0]  rd_data;
  logic        periph_we;
  logic [5:0]  periph_addr;
  logic [7:0]  periph_wdata;
  logic        rwp_event;
  logic [12:0] rwp_addr;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  bit        m_ram_mode;
  int        m_bank;
  logic [7:0] m_mem [NRAM*1024];
  bit        m_vld [NRAM*1024];

  hsbank_mapper #(.ROM_BANKS(NROM), .RAM_BANKS(NRAM)) u_hsbank_mapper (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .rd_en(rd_en),
    .wr_en(wr_en), .bus_float(bus_float), .bank_lock(bank_lock), .rd_data(rd_data),
    .periph_we(periph_we), .periph_addr(periph_addr), .periph_wdata(periph_wdata),
    .rwp_event(rwp_event), .rwp_addr(rwp_addr)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] exp_rom(input int b, input int o);
    int v;
    v = ((o & 255) ^ ((b * 17) & 255)) + ((o >> 8) & 7);
    return 8'(v & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check comb outputs, then registered ones
  task automatic op(input logic [12:0] a, input bit r, input bit w, input logic [7:0] d,
                    input logic [7:0] fl, input bit lk, input string req);
    int off, idx;
    bit rd_act, exp_pw, exp_ev, known;
    logic [7:0] exp_rd;
    @(negedge clk);
    addr = a; rd_en = r; wr_en = w; wr_data = d; bus_float = fl; bank_lock = lk;
    #1;
    off    = int'(a[11:0]);
    rd_act = r && !w;
    idx    = (m_bank % NRAM) * 1024 + (off & 1023);
    exp_rd = 8'h00;
    known  = 1'b1;
    if (rd_act && a[12]) begin
      if (off >= 12'h800)       exp_rd = exp_rom(NROM - 1, off & 2047);
      else if (!m_ram_mode)     exp_rd = exp_rom(m_bank % NROM, off & 2047);
      else if (off < 12'h400) begin exp_rd = m_mem[idx]; known = m_vld[idx]; end
      else                      exp_rd = fl;
    end
    if (known) check(rd_data == exp_rd, req, rd_data, exp_rd);
    exp_pw = w && !a[12] && (off < 64);
    check(periph_we == exp_pw, {req, "/R4 periph_we"}, periph_we, exp_pw);
    if (exp_pw)
      check(periph_addr == a[5:0] && periph_wdata == d, "R4 periph fields",
            {periph_addr, periph_wdata}, {a[5:0], d});
    exp_ev = rd_act && a[12] && m_ram_mode && off >= 12'h400 && off < 12'h800 && !lk;
    @(posedge clk);
    #1;
    check(rwp_event == exp_ev, "R9 rwp_event", rwp_event, exp_ev);
    if (exp_ev) check(rwp_addr == a, "R9 rwp_addr", rwp_addr, a);
    // update model
    if (exp_pw && a[5:0] == 6'h3F) begin m_ram_mode = 1'b0; m_bank = int'(d); end
    else if (exp_pw && a[5:0] == 6'h3E) begin m_ram_mode = 1'b1; m_bank = int'(d); end
    if (w && a[12] && m_ram_mode && off >= 12'h400 && off < 12'h800) begin
      m_mem[idx] = d; m_vld[idx] = 1'b1;
    end
    if (exp_ev) begin m_mem[idx] = fl; m_vld[idx] = 1'b1; end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    m_ram_mode = 1'b0; m_bank = 0;
    for (int i = 0; i < NRAM*1024; i++) m_vld[i] = 1'b0;
    addr = '0; rd_en = 0; wr_en = 0; wr_data = '0; bus_float = '0; bank_lock = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(rwp_event == 1'b0, "R1 event low after reset", rwp_event, 0);

    // R1 reset bank, R11 contents, R5 fixed upper half
    op(13'h1123, 1, 0, 8'h00, 8'h00, 0, "R1 rom bank0 after reset");
    op(13'h1456, 1, 0, 8'h00, 8'h00, 0, "R11 rom contents");
    op(13'h1A5C, 1, 0, 8'h00, 8'h00, 0, "R5 upper half last bank");
    // R2 select ROM bank 2, also passed through (R4)
    op(13'h003F, 0, 1, 8'h02, 8'h00, 0, "R2 hotspot write");
    op(13'h1321, 1, 0, 8'h00, 8'h00, 0, "R2 lower window bank2");
    op(13'h1F00, 1, 0, 8'h00, 8'h00, 0, "R5 upper half unaffected");
    // R10 writes outside hotspot span / to ROM
    op(13'h0040, 0, 1, 8'h3E, 8'h00, 0, "R10 foreign write no passthrough");
    op(13'h1900, 0, 1, 8'h77, 8'h00, 0, "R10 rom write");
    op(13'h0900, 1, 0, 8'h00, 8'h5A, 0, "R10 read outside window is zero");
    // R3 select RAM bank 1
    op(13'h003E, 0, 1, 8'h01, 8'h00, 0, "R3 ram hotspot");
    op(13'h1405, 0, 1, 8'hAA, 8'h00, 0, "R6 ram write");
    op(13'h1005, 1, 0, 8'h00, 8'h00, 0, "R6 ram readback");
    op(13'h1406, 0, 1, 8'h11, 8'h00, 0, "R6 ram write 2");
    op(13'h1407, 0, 1, 8'h22, 8'h00, 0, "R6 ram write 3");
    // R8 locked write-half read
    op(13'h1406, 1, 0, 8'h00, 8'hC3, 1, "R8 locked read returns float");
    op(13'h1006, 1, 0, 8'h00, 8'h00, 0, "R8 ram unchanged");
    // R7 unlocked corrupting read, R9 event
    op(13'h1406, 1, 0, 8'h00, 8'h9B, 0, "R7 write-half read returns float");
    op(13'h1006, 1, 0, 8'h00, 8'h00, 0, "R7 ram corrupted");
    op(13'h1006, 1, 0, 8'h00, 8'h00, 0, "R9 single-cycle event");
    // R10 write to write half in ROM mode ignored
    op(13'h003F, 0, 1, 8'h01, 8'h00, 0, "R2 back to rom");
    op(13'h1407, 0, 1, 8'h55, 8'h00, 0, "R10 rom-mode write-half write");
    op(13'h1407, 1, 0, 8'h00, 8'hEE, 0, "R10 rom-mode read of 0x407 is rom");
    op(13'h003E, 0, 1, 8'h03, 8'h00, 0, "R3 ram bank 3 wraps to 1");
    op(13'h1007, 1, 0, 8'h00, 8'h00, 0, "R10 ram kept old byte");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [12:0] a;
      bit r, w, lk;
      k = int'($urandom % 8);
      case (k)
        0: a = ($urandom % 2) ? 13'h003F : 13'h003E;
        1: a = 13'($urandom % 64);
        2: a = 13'h0040 + 13'($urandom % 13'h0FC0);
        default: a = 13'h1000 | 13'($urandom % 4096);
      endcase
      w  = (k == 0) ? 1'b1 : (($urandom % 3) == 0);
      r  = ($urandom % 4) != 0;
      lk = ($urandom % 4) == 0;
      op(a, r, w, 8'($urandom), 8'($urandom), lk, "R6/R7 random");
    end
    op(13'h0000, 0, 0, 8'h00, 8'h00, 0, "R10 idle");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule